// File: doc/BRIEF.md
# Inter-processor mailbox bank

A bank of hardware mailboxes through which several processors pass short command messages. Each mailbox has a 64-byte register window on a simple 32-bit register bus. A sender takes an idle mailbox by writing its one-hot identity to the owner register and reading it back. It then names the destinations, fills the data words and triggers the send. The send raises an interrupt at each destination. A destination acknowledges the message, which raises the sender's interrupt. The sender then releases the mailbox back to idle.

Register writes are refused until a 32-bit key has been written to a lock register, so stray writes cannot disturb the mailboxes. Each processor identity has one interrupt output. An output is set while any mailbox holds an unmasked pending bit for that identity. A mailbox acknowledges in one of two ways. In auto-answer mode the destination clears its bit and the clear that empties the destination status counts as the acknowledge. Otherwise the destination writes its identity to the send register.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox is idle, its mode word (offset 0x10) reads 0x10, all interrupt outputs are 0 and the lock register (byte address 0xA00) reads 0.
- R2: A write to any mailbox register is ignored unless the key 0x1ACCE551 was the last value written to 0xA00. While unlocked, 0xA00 reads 1. Writing any other value to 0xA00 locks the bank again.
- R3: Mailbox m occupies byte addresses m*64 to m*64+63. Word offsets are: owner 0x00, destination set 0x04, destination clear 0x08, destination status 0x0C, mode 0x10, interrupt mask 0x14, interrupt clear/pending 0x18, send 0x1C, data word d at 0x20+4d.
- R4: The mode word carries the state in bits [7:4] (0x1 idle, 0x2 claimed, 0x4 sent, 0x8 acknowledged) and auto-answer in bit 0. A write of a one-hot 6-bit value to the owner register of an idle mailbox makes that value the owner and moves the mailbox to claimed. A write of a value that is not one-hot leaves the mailbox idle with owner 0.
- R5: A write to the owner register of a claimed or sent mailbox, or a write of a value other than the owner to an acknowledged one, leaves the owner unchanged.
- R6: A write to the mode word changes only bit 0, and only while the mailbox is claimed.
- R7: A write of exactly the owner's value to the send register of a claimed mailbox moves it to sent and sets a pending bit for each destination status bit. A send by any other value leaves the mailbox claimed.
- R8: In a sent mailbox with auto-answer set, a destination clear that leaves the destination status empty moves the mailbox to acknowledged and sets the owner's pending bit.
- R9: In a sent mailbox, a write to the send register whose value shares a bit with the destination status moves the mailbox to acknowledged and sets the owner's pending bit.
- R10: Writing ones to the interrupt clear register clears those pending bits. Reading that offset returns the pending bits.
- R11: Interrupt output s is high exactly when some mailbox has pending bit s set and mask bit s clear. It reflects a register write right after the write's clock edge.
- R12: A write of the owner's value to the owner register of an acknowledged mailbox returns it to idle. Afterwards the owner reads 0, the destination status reads 0 and the mode word reads 0x10.
- R13: Data words hold and read back any 32-bit value written to them.
- R14: Read data appears on the read data port one clock after the read request is taken. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | 6 | Per-identity interrupt outputs |

## Verification
A register write takes effect at the clock edge that accepts it. The interrupt outputs are combinational from the pending and mask registers, so they carry the write's result right after that edge. Read data passes through one register, so a read taken at edge N shows its value just after edge N. The bench drives each access on a falling edge and lets one rising edge take it. It samples both read data and interrupts at the following falling edge, where every result above is already settled and no later access has started.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int SRC_W  = 6;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [DATA_W-1:0] LOCK_KEY  = 32'h1ACC_E551;
    localparam logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00;

    // one-hot state nibble, shown in mode bits [7:4]
    typedef enum logic [3:0] {
        ST_IDLE  = 4'h1,
        ST_CLAIM = 4'h2,
        ST_SENT  = 4'h4,
        ST_ACK   = 4'h8
    } mb_state_e;

    // word index inside a 64-byte window
    localparam logic [3:0] W_OWNER = 4'd0;
    localparam logic [3:0] W_DSET  = 4'd1;
    localparam logic [3:0] W_DCLR  = 4'd2;
    localparam logic [3:0] W_DSTAT = 4'd3;
    localparam logic [3:0] W_MODE  = 4'd4;
    localparam logic [3:0] W_MASK  = 4'd5;
    localparam logic [3:0] W_ICLR  = 4'd6;
    localparam logic [3:0] W_SEND  = 4'd7;
    localparam int         W_DATA0 = 8;

    typedef struct packed {
        logic [3:0]        word;
        logic [DATA_W-1:0] data;
    } mb_wr_t;

    function automatic logic is_onehot(input logic [SRC_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/mbox_lock.sv
module mbox_lock
    import mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    always_ff @(posedge clk) begin
        if (rst)
            unlocked <= 1'b0;
        else if (wr)
            unlocked <= (wdata == LOCK_KEY);
    end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int NUM_DATA = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  mb_wr_t                     wr,
    output mb_state_e                  state,
    output logic [SRC_W-1:0]           owner,
    output logic [SRC_W-1:0]           dest,
    output logic                       auto_ans,
    output logic [SRC_W-1:0]           mask,
    output logic [SRC_W-1:0]           pend,
    output logic [NUM_DATA*DATA_W-1:0] data_flat
);
    logic [DATA_W-1:0] data_q [NUM_DATA];
    logic [SRC_W-1:0]  v;
    logic [SRC_W-1:0]  dest_after_clr;

    assign v              = wr.data[SRC_W-1:0];
    assign dest_after_clr = dest & ~v;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            owner    <= '0;
            dest     <= '0;
            auto_ans <= 1'b0;
            mask     <= '0;
            pend     <= '0;
            for (int i = 0; i < NUM_DATA; i++) data_q[i] <= '0;
        end else if (wr_en) begin
            case (wr.word)
                W_OWNER: begin
                    if (state == ST_IDLE && is_onehot(v)) begin
                        owner <= v;
                        state <= ST_CLAIM;
                    end else if (state == ST_ACK && v == owner) begin
                        owner    <= '0;
                        dest     <= '0;
                        auto_ans <= 1'b0;
                        state    <= ST_IDLE;
                    end
                end
                W_DSET: dest <= dest | v;
                W_DCLR: begin
                    dest <= dest_after_clr;
                    if (state == ST_SENT && auto_ans && dest != '0 && dest_after_clr == '0) begin
                        state <= ST_ACK;
                        pend  <= pend | owner;
                    end
                end
                W_MODE: if (state == ST_CLAIM) auto_ans <= wr.data[0];
                W_MASK: mask <= v;
                W_ICLR: pend <= pend & ~v;
                W_SEND: begin
                    if (state == ST_CLAIM && v == owner) begin
                        state <= ST_SENT;
                        pend  <= pend | dest;
                    end else if (state == ST_SENT && (v & dest) != '0) begin
                        state <= ST_ACK;
                        pend  <= pend | owner;
                    end
                end
                default: begin
                    for (int i = 0; i < NUM_DATA; i++)
                        if (wr.word == 4'(W_DATA0 + i)) data_q[i] <= wr.data;
                end
            endcase
        end
    end

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_flat
        assign data_flat[i*DATA_W +: DATA_W] = data_q[i];
    end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4
) (
    input  logic [NUM_MBOX*SRC_W-1:0] pend_flat,
    input  logic [NUM_MBOX*SRC_W-1:0] mask_flat,
    output logic [SRC_W-1:0]          irq
);
    always_comb begin
        irq = '0;
        for (int m = 0; m < NUM_MBOX; m++)
            irq = irq | (pend_flat[m*SRC_W +: SRC_W] & ~mask_flat[m*SRC_W +: SRC_W]);
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4,
    parameter int NUM_DATA = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [SRC_W-1:0]  irq
);
    localparam int WIN_W = ADDR_W - 6;

    logic [WIN_W-1:0] win_idx;
    logic [3:0]       word;
    logic             in_range;
    logic             lock_hit;
    logic             unlocked;
    logic             wr_ok;
    mb_wr_t           wr;

    mb_state_e         st_q   [NUM_MBOX];
    logic [SRC_W-1:0]  own_q  [NUM_MBOX];
    logic [SRC_W-1:0]  dst_q  [NUM_MBOX];
    logic              auto_q [NUM_MBOX];
    logic [SRC_W-1:0]  msk_q  [NUM_MBOX];
    logic [SRC_W-1:0]  pnd_q  [NUM_MBOX];
    logic [NUM_DATA*DATA_W-1:0] dat_q [NUM_MBOX];

    logic [NUM_MBOX*4-1:0]     st_flat;
    logic [NUM_MBOX*SRC_W-1:0] own_flat;
    logic [NUM_MBOX*SRC_W-1:0] pend_flat;
    logic [NUM_MBOX*SRC_W-1:0] mask_flat;

    logic [31:0] rd_val;

    assign win_idx  = bus_addr[ADDR_W-1:6];
    assign word     = bus_addr[5:2];
    assign in_range = (32'(win_idx) < NUM_MBOX) && (bus_addr[1:0] == 2'b00);
    assign lock_hit = (bus_addr == LOCK_ADDR);
    assign wr_ok    = bus_en && bus_we && unlocked && in_range;
    assign wr       = '{word: word, data: bus_wdata};

    mbox_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_en && bus_we && lock_hit),
        .wdata    (bus_wdata),
        .unlocked (unlocked)
    );

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mb
        mbox_chan #(.NUM_DATA(NUM_DATA)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_ok && (win_idx == WIN_W'(g))),
            .wr        (wr),
            .state     (st_q[g]),
            .owner     (own_q[g]),
            .dest      (dst_q[g]),
            .auto_ans  (auto_q[g]),
            .mask      (msk_q[g]),
            .pend      (pnd_q[g]),
            .data_flat (dat_q[g])
        );
        assign st_flat[g*4 +: 4]         = st_q[g];
        assign own_flat[g*SRC_W +: SRC_W]  = own_q[g];
        assign pend_flat[g*SRC_W +: SRC_W] = pnd_q[g];
        assign mask_flat[g*SRC_W +: SRC_W] = msk_q[g];
    end

    mbox_irq #(.NUM_MBOX(NUM_MBOX)) u_irq (
        .pend_flat (pend_flat),
        .mask_flat (mask_flat),
        .irq       (irq)
    );

    always_comb begin
        rd_val = '0;
        if (lock_hit) begin
            rd_val = {31'b0, unlocked};
        end else if (in_range) begin
            for (int m = 0; m < NUM_MBOX; m++) begin
                if (win_idx == WIN_W'(m)) begin
                    case (word)
                        W_OWNER: rd_val = 32'(own_q[m]);
                        W_DSTAT: rd_val = 32'(dst_q[m]);
                        W_MODE:  rd_val = {24'b0, st_q[m], 3'b000, auto_q[m]};
                        W_MASK:  rd_val = 32'(msk_q[m]);
                        W_ICLR:  rd_val = 32'(pnd_q[m]);
                        default: begin
                            for (int d = 0; d < NUM_DATA; d++)
                                if (word == 4'(W_DATA0 + d)) rd_val = dat_q[m][d*DATA_W +: DATA_W];
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_en && !bus_we)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk
    import mbox_pkg::*;
#(
    parameter int NUM_MBOX = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_en,
    input logic                      bus_we,
    input logic [11:0]               bus_addr,
    input logic                      unlocked,
    input logic [NUM_MBOX*4-1:0]     st_flat,
    input logic [NUM_MBOX*SRC_W-1:0] own_flat,
    input logic [NUM_MBOX*SRC_W-1:0] pend_flat
);
    // R2
    locked_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && bus_en && bus_we && bus_addr != LOCK_ADDR)
            |=> ($stable(st_flat) && $stable(own_flat)));

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_chk
        logic [3:0]       st;
        logic [SRC_W-1:0] own;
        logic [SRC_W-1:0] pnd;
        assign st  = st_flat[m*4 +: 4];
        assign own = own_flat[m*SRC_W +: SRC_W];
        assign pnd = pend_flat[m*SRC_W +: SRC_W];

        // R4
        state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot(st));

        // R5
        owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (st == ST_CLAIM || st == ST_SENT) |=> $stable(own));

        // R8
        ack_irq_chk: assert property (@(posedge clk) disable iff (rst)
            (st == ST_ACK && $past(st) == ST_SENT) |-> ((pnd & own) != '0));

        // R12
        release_chk: assert property (@(posedge clk) disable iff (rst)
            (st == ST_IDLE && $past(st) == ST_ACK) |-> (own == '0));
    end
endmodule

bind mbox_bank mbox_bank_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .unlocked  (unlocked),
    .st_flat   (st_flat),
    .own_flat  (own_flat),
    .pend_flat (pend_flat)
);

// File: tb/tb_mbox_bank.sv
`timescale 1ns/1ps
module tb_mbox_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mbox_bank dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // {op, addr, wdata, expected}; op 0 write, 1 read and compare, 2 irq compare
    localparam int NV = 36;
    localparam logic [77:0] VEC [NV] = '{
        {2'd0, 12'hA00, 32'h1ACCE551, 32'h0},        // R2 unlock
        {2'd1, 12'hA00, 32'h0, 32'h00000001},        // R2
        {2'd1, 12'h050, 32'h0, 32'h00000010},        // R3 idle mode
        {2'd0, 12'h040, 32'h01, 32'h0},              // R4 claim
        {2'd1, 12'h040, 32'h0, 32'h00000001},        // R4
        {2'd1, 12'h050, 32'h0, 32'h00000020},        // R4
        {2'd0, 12'h040, 32'h02, 32'h0},              // R5 foreign claim
        {2'd1, 12'h040, 32'h0, 32'h00000001},        // R5
        {2'd0, 12'h050, 32'hFF, 32'h0},              // R6
        {2'd1, 12'h050, 32'h0, 32'h00000021},        // R6
        {2'd0, 12'h044, 32'h08, 32'h0},              // dest set
        {2'd1, 12'h04C, 32'h0, 32'h00000008},        // R3
        {2'd0, 12'h060, 32'hCAFE0001, 32'h0},        // R13
        {2'd0, 12'h064, 32'h12345678, 32'h0},
        {2'd1, 12'h060, 32'h0, 32'hCAFE0001},        // R13
        {2'd1, 12'h064, 32'h0, 32'h12345678},        // R13
        {2'd0, 12'h05C, 32'h02, 32'h0},              // R7 foreign send
        {2'd1, 12'h050, 32'h0, 32'h00000021},        // R7
        {2'd0, 12'h05C, 32'h01, 32'h0},              // R7 send
        {2'd1, 12'h050, 32'h0, 32'h00000041},        // R7
        {2'd2, 12'h000, 32'h0, 32'h00000008},        // R11
        {2'd1, 12'h058, 32'h0, 32'h00000008},        // R10
        {2'd0, 12'h058, 32'h08, 32'h0},              // R10 clear
        {2'd2, 12'h000, 32'h0, 32'h00000000},        // R10
        {2'd0, 12'h048, 32'h08, 32'h0},              // R8 last dest cleared
        {2'd1, 12'h050, 32'h0, 32'h00000081},        // R8
        {2'd2, 12'h000, 32'h0, 32'h00000001},        // R8
        {2'd0, 12'h054, 32'h01, 32'h0},              // R11 mask
        {2'd2, 12'h000, 32'h0, 32'h00000000},        // R11
        {2'd1, 12'h058, 32'h0, 32'h00000001},        // R11 still pending
        {2'd0, 12'h058, 32'h01, 32'h0},
        {2'd0, 12'h054, 32'h00, 32'h0},
        {2'd0, 12'h040, 32'h01, 32'h0},              // R12 release
        {2'd1, 12'h050, 32'h0, 32'h00000010},        // R12
        {2'd1, 12'h040, 32'h0, 32'h00000000},        // R12
        {2'd1, 12'h04C, 32'h0, 32'h00000000}         // R12
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        check(tag, bus_rdata, exp);   // R14 one edge after the request
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        check("R1 irq", {26'b0, irq}, 32'h0);
        rd_chk("R1 mode", 12'h010, 32'h10);
        rd_chk("R1 lock", 12'hA00, 32'h0);
        // R2 writes ignored while locked
        wr(12'h000, 32'h01);
        rd_chk("R2 locked owner", 12'h000, 32'h0);
        rd_chk("R2 locked mode", 12'h010, 32'h10);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [11:0] a;
            logic [31:0] d, e;
            {op, a, d, e} = VEC[i];
            if (op == 2'd0) wr(a, d);
            else if (op == 2'd1) rd_chk($sformatf("vec%0d", i), a, e);
            else begin
                @(negedge clk);
                check($sformatf("vec%0d irq", i), {26'b0, irq}, e);
            end
        end

        // R9 manual acknowledge on mailbox 2
        wr(12'h080, 32'h04);
        wr(12'h084, 32'h01);
        wr(12'h09C, 32'h04);
        @(negedge clk);
        check("R9 dest irq", {26'b0, irq}, 32'h01);
        wr(12'h09C, 32'h01);
        rd_chk("R9 ack mode", 12'h090, 32'h80);
        @(negedge clk);
        check("R9 owner irq", {26'b0, irq}, 32'h05);
        // R5 release by non-owner is ignored
        wr(12'h080, 32'h01);
        rd_chk("R5 ack owner", 12'h080, 32'h04);
        // R4 non-one-hot claim on mailbox 3
        wr(12'h0C0, 32'h03);
        rd_chk("R4 bad claim owner", 12'h0C0, 32'h0);
        rd_chk("R4 bad claim mode", 12'h0D0, 32'h10);
        // R6 mode write in idle is ignored
        wr(12'h0D0, 32'h01);
        rd_chk("R6 idle mode", 12'h0D0, 32'h10);
        // R14 unmapped read
        rd_chk("R14 unmapped", 12'h900, 32'h0);
        // R2 relock
        wr(12'hA00, 32'h0);
        rd_chk("R2 relock", 12'hA00, 32'h0);
        wr(12'h084, 32'h3E);
        rd_chk("R2 relocked dest", 12'h08C, 32'h01);
        // R3 window of mailbox 3 data word 1
        wr(12'hA00, 32'h1ACCE551);
        wr(12'h0E4, 32'hA5A55A5A);
        rd_chk("R3 data window", 12'h0E4, 32'hA5A55A5A);
        rd_chk("R3 other window", 12'h064, 32'h12345678);

        finish_run();
    end
endmodule